// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small chip. A serial test clock, a mode-select line and a serial data input drive the standard sixteen-state TAP controller. A 4-bit instruction register, loaded through the instruction scan path, picks which data register sits between the serial input and the serial output. The data registers are a 32-bit identification word, a one-bit bypass stage, a one-bit register that holds the chip in internal reset, and a boundary-scan chain with four cells for each port pin.

In normal operation each pin carries the pull-up disable, output enable and output data that the core drives. Loading the external-test opcode hands the pins to the boundary-scan update latches at once. Capture, shift and update cycles then read the pad levels and drive test patterns onto the board. The reset register's latched bit is ORed with an external reset request. While that combined request is high and external test is not active, all pins are released to tri-state. This is how a test floats the outputs.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard 16-state TAP transitions on rising TCK, reaches Test-Logic-Reset after five consecutive rising edges with TMS high from any state, and enters it asynchronously while trstN is low.
- R2: In Test-Logic-Reset the active instruction becomes IDCODE (0x1). Under IDCODE, Capture-DR loads a 32-bit word with bit 0 = 1, bits 11:1 = manufacturer code, bits 27:12 = device number and bits 31:28 = version, each field a parameter.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, so the first four bits shifted out are 1,0,0,0. The shifted-in opcode takes effect in Update-IR.
- R4: Opcode 0x0 selects the boundary-scan chain, 0x1 the identification word, 0xC the reset register and 0xF the bypass stage. Every other opcode also selects bypass. Bypass captures 0 and delays TDI by one stage.
- R5: Every shift register moves its least significant bit out first, with TDI entering at the top. TDO and tdoEn change on falling TCK. tdoEn is high only in Shift-IR and Shift-DR, and TDO is 0 while tdoEn is low.
- R6: The boundary chain holds 4 bits per pin. Pin p owns bits 4p..4p+3: pull-up disable, output enable, output data, input data, with bit 0 nearest TDO. Under external test, Capture-DR loads the three control bits from the values currently applied to the pin and loads the input bit from padIn.
- R7: Under external test, Update-DR copies each pin's three control bits from the chain into its update latches. The input-data bit does not affect any pin.
- R8: While the active instruction is external test, pinPuDis, pinOe and pinOut come from the update latches, starting with Update-IR. The latches clear to 0 in Test-Logic-Reset. Under any other instruction the pins follow the core inputs unless R10 applies.
- R9: Under opcode 0xC the one-bit reset register captures its current latched value, and Update-DR latches the shifted bit. intRstReq is the latched bit OR extRstReq. The latch keeps its value across other instructions and clears in Test-Logic-Reset.
- R10: While intRstReq is high and external test is not active, pinPuDis, pinOe and pinOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdoEn | output | 1 | High while TDO carries shift data |
| extRstReq | input | 1 | Reset request from other on-chip sources |
| intRstReq | output | 1 | Combined internal reset request |
| coreOe | input | PIN_COUNT | Core output enables |
| coreOut | input | PIN_COUNT | Core output data |
| corePuDis | input | PIN_COUNT | Core pull-up disables |
| padIn | input | PIN_COUNT | Levels sensed at the pads |
| pinOe | output | PIN_COUNT | Output enable applied to each pad |
| pinOut | output | PIN_COUNT | Output data applied to each pad |
| pinPuDis | output | PIN_COUNT | Pull-up disable applied to each pad |

## Verification
The bench builds the block with PIN_COUNT = 3, which gives a 12-bit chain. Every cell position of every pin shows up in the captured and shifted words, and the chain stays short enough to check bit by bit. The identification fields are overridden to version 0x6, device 0xB2C5 and manufacturer 0x03A. These values are asymmetric and non-zero, so a swapped or shifted field boundary shows up in the 32 serial bits. Distinct core, pad and shifted patterns on the three pins expose a cell ordering that is crossed between pins or within a pin.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_RSTREG = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam int CELLS_PER_PIN = 4;
  localparam int CELL_PU  = 0;
  localparam int CELL_OE  = 1;
  localparam int CELL_OUT = 2;
  localparam int CELL_IN  = 3;

  localparam int ID_W = 32;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_RST, SEL_BSC} drSel_e;

  typedef struct packed {
    logic   capDr;
    logic   shDr;
    logic   updDr;
    logic   shIr;
    logic   tlr;
    drSel_e sel;
  } drStrobe_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  output drStrobe_t           strb,
  output logic                irOut,
  output logic                extestOn,
  output tapState_e           tapState,
  output logic [IR_W-1:0]     curInstr
);

  tapState_e nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TLR;
    else        tapState <= nextState;
  end

  always_comb begin
    nextState = tapState;
    unique case (tapState)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SH_DR;
      SH_DR:  nextState = tms ? EX1_DR : SH_DR;
      EX1_DR: nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR: nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR: nextState = tms ? UPD_DR : SH_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SH_IR;
      SH_IR:  nextState = tms ? EX1_IR : SH_IR;
      EX1_IR: nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR: nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR: nextState = tms ? UPD_IR : SH_IR;
      UPD_IR: nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  // instruction path: capture pattern, LSB-first shift, update into active opcode
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irReg   <= OP_IDCODE;
    end else begin
      case (tapState)
        TLR:    irReg   <= OP_IDCODE;
        CAP_IR: irShift <= IR_CAPTURE;
        SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        UPD_IR: irReg   <= irShift;
        default: ;
      endcase
    end
  end

  drSel_e selDecode;
  always_comb begin
    case (irReg)
      OP_EXTEST: selDecode = SEL_BSC;
      OP_IDCODE: selDecode = SEL_ID;
      OP_RSTREG: selDecode = SEL_RST;
      default:   selDecode = SEL_BYP;
    endcase
  end

  always_comb begin
    strb.capDr = (tapState == CAP_DR);
    strb.shDr  = (tapState == SH_DR);
    strb.updDr = (tapState == UPD_DR);
    strb.shIr  = (tapState == SH_IR);
    strb.tlr   = (tapState == TLR);
    strb.sel   = selDecode;
  end

  assign irOut    = irShift[0];
  assign extestOn = (irReg == OP_EXTEST);
  assign curInstr = irReg;

endmodule

// File: rtl/scan_tap_dpath.sv
module scan_tap_dpath
  import scan_tap_pkg::*;
#(
  parameter int          PIN_COUNT  = 4,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_DEVICE  = 16'h0042,
  parameter logic [10:0] ID_MFR     = 11'h01F
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tdi,
  input  drStrobe_t            strb,
  input  logic                 irOut,
  input  logic                 extestOn,
  input  logic                 extRstReq,
  input  logic [PIN_COUNT-1:0] coreOe,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] corePuDis,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic                 tdo,
  output logic                 tdoEn,
  output logic                 intRstReq,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinPuDis
);

  localparam int CHAIN_W = CELLS_PER_PIN * PIN_COUNT;
  localparam logic [ID_W-1:0] ID_VAL = {ID_VERSION, ID_DEVICE, ID_MFR, 1'b1};

  logic [CHAIN_W-1:0]   bsChain;
  logic [CHAIN_W-1:0]   bsCapture;
  logic [PIN_COUNT-1:0] updPu, updOe, updOut;
  logic [ID_W-1:0]      idShift;
  logic                 bypBit;
  logic                 rstShift;
  logic                 rstLatch;
  logic                 drOut;

  // ---------------- pin drive selection ----------------
  always_comb begin
    if (extestOn) begin
      pinPuDis = updPu;
      pinOe    = updOe;
      pinOut   = updOut;
    end else if (intRstReq) begin
      pinPuDis = '0;
      pinOe    = '0;
      pinOut   = '0;
    end else begin
      pinPuDis = corePuDis;
      pinOe    = coreOe;
      pinOut   = coreOut;
    end
  end

  // ---------------- per-pin boundary cells ----------------
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_cell
    localparam int BASE = CELLS_PER_PIN * p;

    assign bsCapture[BASE + CELL_PU]  = pinPuDis[p];
    assign bsCapture[BASE + CELL_OE]  = pinOe[p];
    assign bsCapture[BASE + CELL_OUT] = pinOut[p];
    assign bsCapture[BASE + CELL_IN]  = padIn[p];

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN) begin
        updPu[p]  <= 1'b0;
        updOe[p]  <= 1'b0;
        updOut[p] <= 1'b0;
      end else if (strb.tlr) begin
        updPu[p]  <= 1'b0;
        updOe[p]  <= 1'b0;
        updOut[p] <= 1'b0;
      end else if (strb.updDr && strb.sel == SEL_BSC) begin
        updPu[p]  <= bsChain[BASE + CELL_PU];
        updOe[p]  <= bsChain[BASE + CELL_OE];
        updOut[p] <= bsChain[BASE + CELL_OUT];
      end
    end
  end

  // ---------------- boundary chain shifter ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bsChain <= '0;
    else if (strb.sel == SEL_BSC) begin
      if (strb.capDr)     bsChain <= bsCapture;
      else if (strb.shDr) bsChain <= {tdi, bsChain[CHAIN_W-1:1]};
    end
  end

  // ---------------- identification word ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idShift <= '0;
    else if (strb.sel == SEL_ID) begin
      if (strb.capDr)     idShift <= ID_VAL;
      else if (strb.shDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // ---------------- bypass stage ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypBit <= 1'b0;
    else if (strb.sel == SEL_BYP) begin
      if (strb.capDr)     bypBit <= 1'b0;
      else if (strb.shDr) bypBit <= tdi;
    end
  end

  // ---------------- reset register ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      rstShift <= 1'b0;
      rstLatch <= 1'b0;
    end else if (strb.tlr) begin
      rstLatch <= 1'b0;
    end else if (strb.sel == SEL_RST) begin
      if (strb.capDr)      rstShift <= rstLatch;
      else if (strb.shDr)  rstShift <= tdi;
      else if (strb.updDr) rstLatch <= rstShift;
    end
  end

  assign intRstReq = rstLatch | extRstReq;

  // ---------------- serial output ----------------
  always_comb begin
    unique case (strb.sel)
      SEL_BSC: drOut = bsChain[0];
      SEL_ID:  drOut = idShift[0];
      SEL_RST: drOut = rstShift;
      default: drOut = bypBit;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shIr | strb.shDr;
      if (strb.shIr)      tdo <= irOut;
      else if (strb.shDr) tdo <= drOut;
      else                tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          PIN_COUNT  = 4,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_DEVICE  = 16'h0042,
  parameter logic [10:0] ID_MFR     = 11'h01F
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tms,
  input  logic                 tdi,
  output logic                 tdo,
  output logic                 tdoEn,
  input  logic                 extRstReq,
  output logic                 intRstReq,
  input  logic [PIN_COUNT-1:0] coreOe,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] corePuDis,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinPuDis
);

  drStrobe_t       strb;
  logic            irOut;
  logic            extestOn;
  tapState_e       tapState;
  logic [IR_W-1:0] curInstr;

  scan_tap_ctrl ctrl_i (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tdi      (tdi),
    .strb     (strb),
    .irOut    (irOut),
    .extestOn (extestOn),
    .tapState (tapState),
    .curInstr (curInstr)
  );

  scan_tap_dpath #(
    .PIN_COUNT  (PIN_COUNT),
    .ID_VERSION (ID_VERSION),
    .ID_DEVICE  (ID_DEVICE),
    .ID_MFR     (ID_MFR)
  ) dpath_i (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .strb      (strb),
    .irOut     (irOut),
    .extestOn  (extestOn),
    .extRstReq (extRstReq),
    .coreOe    (coreOe),
    .coreOut   (coreOut),
    .corePuDis (corePuDis),
    .padIn     (padIn),
    .tdo       (tdo),
    .tdoEn     (tdoEn),
    .intRstReq (intRstReq),
    .pinOe     (pinOe),
    .pinOut    (pinOut),
    .pinPuDis  (pinPuDis)
  );

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int PIN_COUNT = 4
) (
  input logic                 tck,
  input logic                 trstN,
  input logic                 tms,
  input logic                 tdo,
  input logic                 tdoEn,
  input logic                 extRstReq,
  input logic                 intRstReq,
  input logic                 extestOn,
  input tapState_e            tapState,
  input logic [IR_W-1:0]      curInstr,
  input logic [PIN_COUNT-1:0] coreOe,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinPuDis
);

  logic [2:0] onesCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              onesCnt <= '0;
    else if (!tms)           onesCnt <= '0;
    else if (onesCnt != 3'd5) onesCnt <= onesCnt + 3'd1;
  end

  AST_TMS_FIVE_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt == 3'd5) |-> (tapState == TLR)); // R1

  AST_IDCODE_AFTER_TLR: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TLR) |=> (curInstr == OP_IDCODE)); // R2

  AST_TDOEN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (tapState == SH_IR || tapState == SH_DR)); // R5

  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo); // R5

  AST_CORE_PASS: assert property (@(posedge tck) disable iff (!trstN)
    (!extestOn && !intRstReq) |-> (pinOe == coreOe)); // R8

  AST_EXT_RST_OR: assert property (@(posedge tck) disable iff (!trstN)
    extRstReq |-> intRstReq); // R9

  AST_RST_TRISTATE: assert property (@(posedge tck) disable iff (!trstN)
    (intRstReq && !extestOn) |-> (pinOe == '0 && pinOut == '0 && pinPuDis == '0)); // R10

endmodule

bind scan_tap scan_tap_chk #(.PIN_COUNT(PIN_COUNT)) chk_i (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .tdo       (tdo),
  .tdoEn     (tdoEn),
  .extRstReq (extRstReq),
  .intRstReq (intRstReq),
  .extestOn  (extestOn),
  .tapState  (tapState),
  .curInstr  (curInstr),
  .coreOe    (coreOe),
  .pinOe     (pinOe),
  .pinOut    (pinOut),
  .pinPuDis  (pinPuDis)
);

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;

  localparam int          NP      = 3;
  localparam logic [3:0]  T_VER   = 4'h6;
  localparam logic [15:0] T_DEV   = 16'hB2C5;
  localparam logic [10:0] T_MFR   = 11'h03A;
  localparam logic [31:0] EXP_ID  = {T_VER, T_DEV, T_MFR, 1'b1};
  localparam int          CW      = 4 * NP;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn;
  logic extRstReq = 1'b0;
  logic intRstReq;
  logic [NP-1:0] coreOe = '0, coreOut = '0, corePuDis = '0, padIn = '0;
  logic [NP-1:0] pinOe, pinOut, pinPuDis;

  always #2 tck = ~tck;

  scan_tap #(
    .PIN_COUNT (NP),
    .ID_VERSION(T_VER),
    .ID_DEVICE (T_DEV),
    .ID_MFR    (T_MFR)
  ) dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .extRstReq(extRstReq), .intRstReq(intRstReq),
    .coreOe(coreOe), .coreOut(coreOut), .corePuDis(corePuDis), .padIn(padIn),
    .pinOe(pinOe), .pinOut(pinOut), .pinPuDis(pinPuDis)
  );

  typedef struct {
    logic  v;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each bit shown on TDO is compared to the queue head
  always begin
    @(negedge tck);
    #1;
    if (tdoEn && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected shift bit", {63'd0, tdo}, 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(tdo === e.v, e.req, {63'd0, tdo}, {63'd0, e.v});
      end
    end
  end

  task automatic clk(input logic tmsV, input logic tdiV);
    tms = tmsV;
    tdi = tdiV;
    @(posedge tck);
    #1;
  endtask

  task automatic tapReset();
    for (int i = 0; i < 5; i++) clk(1'b1, 1'b0);
    clk(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [3:0] op);
    clk(1'b1, 1'b0);
    clk(1'b1, 1'b0);
    clk(1'b0, 1'b0);
    clk(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) expQ.push_back('{v: (i == 0), req: "R3 capture pattern"});
    for (int i = 0; i < 4; i++) clk(i == 3, op[i]);
    clk(1'b1, 1'b0);
    clk(1'b0, 1'b0);
  endtask

  task automatic shiftDr(input int n, input logic [63:0] din, input logic [63:0] dexp, input string req);
    clk(1'b1, 1'b0);
    clk(1'b0, 1'b0);
    clk(1'b0, 1'b0);
    for (int i = 0; i < n; i++) expQ.push_back('{v: dexp[i], req: req});
    for (int i = 0; i < n; i++) clk(i == n - 1, din[i]);
    clk(1'b1, 1'b0);
    clk(1'b0, 1'b0);
    check(expQ.size() == 0, "R5 bits left unshifted", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] capA, shA, capB;
    logic [NP-1:0] tP, tO, tQ;

    coreOe = 3'b101; coreOut = 3'b011; corePuDis = 3'b110; padIn = 3'b010;
    #9;
    // reset state
    check(tdoEn == 1'b0, "R5 reset tdoEn", {63'd0, tdoEn}, 64'd0);
    check(intRstReq == 1'b0, "R9 reset intRstReq", {63'd0, intRstReq}, 64'd0);
    check(pinOe == coreOe, "R8 reset pins follow core", 64'(pinOe), 64'(coreOe));
    trstN = 1'b1;
    @(posedge tck); #1;
    clk(1'b0, 1'b0);

    // R2: default instruction is IDCODE
    shiftDr(32, 64'd0, {32'd0, EXP_ID}, "R2 idcode after reset");
    check(tdo == 1'b0 && tdoEn == 1'b0, "R5 idle output", {62'd0, tdoEn, tdo}, 64'd0);

    // R4: bypass opcode
    loadIr(4'hF);
    shiftDr(8, 64'hB2, {56'd0, 8'hB2 << 1}, "R4 bypass 0xF");
    // R4: unassigned opcode acts as bypass
    loadIr(4'h5);
    shiftDr(8, 64'h6D, {56'd0, 8'h6D << 1}, "R4 bypass unassigned 0x5");

    // external test
    tapReset();
    check(pinOe == coreOe && pinOut == coreOut, "R8 core pass before extest", 64'(pinOe), 64'(coreOe));
    loadIr(4'h0);
    check(pinOe == 0 && pinOut == 0 && pinPuDis == 0, "R8 latches drive on IR load",
          {pinOe, pinOut, pinPuDis}, 64'd0);
    tP = 3'b001; tO = 3'b011; tQ = 3'b110;
    for (int p = 0; p < NP; p++) begin
      capA[4*p+0] = 1'b0; capA[4*p+1] = 1'b0; capA[4*p+2] = 1'b0; capA[4*p+3] = padIn[p];
      shA[4*p+0] = tP[p]; shA[4*p+1] = tO[p]; shA[4*p+2] = tQ[p]; shA[4*p+3] = 1'b1;
    end
    shiftDr(CW, 64'(shA), 64'(capA), "R6 capture cleared latches and pads");
    check(pinPuDis == tP, "R7 pull-up disable update", 64'(pinPuDis), 64'(tP));
    check(pinOe == tO, "R7 output enable update", 64'(pinOe), 64'(tO));
    check(pinOut == tQ, "R7 output data update", 64'(pinOut), 64'(tQ));
    padIn = 3'b101;
    for (int p = 0; p < NP; p++) begin
      capB[4*p+0] = tP[p]; capB[4*p+1] = tO[p]; capB[4*p+2] = tQ[p]; capB[4*p+3] = padIn[p];
    end
    shiftDr(CW, 64'd0, 64'(capB), "R6 capture applied values");
    check(pinOe == 0 && pinOut == 0 && pinPuDis == 0, "R7 zero pattern update",
          {pinOe, pinOut, pinPuDis}, 64'd0);
    loadIr(4'hF);
    check(pinOe == coreOe && pinOut == coreOut && pinPuDis == corePuDis, "R8 core pass after extest",
          {pinOe, pinOut, pinPuDis}, {coreOe, coreOut, corePuDis});

    // reset register
    loadIr(4'hC);
    shiftDr(1, 64'd1, 64'd0, "R9 reset reg captures 0");
    check(intRstReq == 1'b1, "R9 reset latched", {63'd0, intRstReq}, 64'd1);
    check(pinOe == 0 && pinOut == 0 && pinPuDis == 0, "R10 tri-state under reset",
          {pinOe, pinOut, pinPuDis}, 64'd0);
    loadIr(4'hF);
    check(intRstReq == 1'b1, "R9 latch held across instructions", {63'd0, intRstReq}, 64'd1);
    loadIr(4'hC);
    shiftDr(1, 64'd0, 64'd1, "R9 reset reg captures latch");
    check(intRstReq == 1'b0, "R9 reset released", {63'd0, intRstReq}, 64'd0);
    extRstReq = 1'b1;
    #1;
    check(intRstReq == 1'b1, "R9 external reset ORed", {63'd0, intRstReq}, 64'd1);
    check(pinOe == 0, "R10 tri-state under external reset", 64'(pinOe), 64'd0);
    extRstReq = 1'b0;
    shiftDr(1, 64'd1, 64'd0, "R9 set again");
    tapReset();
    check(intRstReq == 1'b0, "R9 latch cleared by TMS reset", {63'd0, intRstReq}, 64'd0);
    shiftDr(32, 64'd0, {32'd0, EXP_ID}, "R1 R2 idcode after TMS reset");

    // asynchronous test reset from a non-default instruction
    loadIr(4'h0);
    clk(1'b1, 1'b0);
    trstN = 1'b0;
    #1;
    check(tdoEn == 1'b0, "R1 async reset output", {63'd0, tdoEn}, 64'd0);
    check(pinOe == coreOe, "R1 async reset leaves extest", 64'(pinOe), 64'(coreOe));
    @(posedge tck); #1;
    trstN = 1'b1;
    clk(1'b0, 1'b0);
    shiftDr(32, 64'd0, {32'd0, EXP_ID}, "R1 R2 idcode after async reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule